// File: doc/BRIEF.md
# Serial Bit-Clock Source Selector

This block decides which bit clock an audio serial port should use. In one case the port runs on a bit clock supplied from outside. In the other it runs on a bit clock made inside from the master clock. Both the external bit clock (`sclk_in`) and the word-select clock (`lrck_in`) are resynchronised into the master clock domain. The block then counts rising bit-clock edges within each half of the word-select period, and keeps track of how many word-select periods have passed with no bit-clock activity.

When enough bit-clock edges arrive inside one word-select half, the block switches to the external clock. From then on, each detected external rising edge produces one strobe on `bit_stb`. When the external clock goes silent for long enough, the block falls back to an internal strobe. That strobe is divided from the master clock and restarted on every word-select edge, so it stays locked to both clocks. A frame-start pulse marks each word-select rising edge, so that downstream shifters can load MSB-first two's-complement words.

All ports are plain control or strobe pins. There is no data stream and so no valid/ready handshake. The strobes are single-cycle pulses that downstream logic has to take in the cycle they appear.

Top module: `sclk_mode_detect`

## Requirements
- R1: While `rst_n` is low, `ext_mode` is 0 (internal mode) and `frame_stb` is 0, and every counter is cleared.
- R2: In internal mode the master clock is assumed to run at 384 times the word-select rate. `bit_stb` then gives 32 pulses per word-select period for `fmt`=00, 48 for 01, and 64 for both 10 and 11. This is one pulse every 12, 8 or 6 master clocks.
- R3: In internal mode the divider restarts on each synchronised word-select edge, so `bit_stb` is high in every cycle in which `frame_stb` is high.
- R4: `frame_stb` is a single-cycle pulse, given once per word-select period on the synchronised rising edge of `lrck_in`. It follows that edge after two synchroniser stages.
- R5: The block sets `ext_mode` to 1 in the cycle after the 16th synchronised rising edge of `sclk_in` within one word-select half. This holds whether `lrck_in` is high or low during that half.
- R6: Rising edges of `sclk_in` are counted separately for each word-select half. Fifteen edges in one half do not set `ext_mode`. Edges split across a word-select edge (10 + 10) do not set `ext_mode` either.
- R7: In external mode `bit_stb` pulses exactly once per synchronised `sclk_in` rising edge, and no internally divided strobes appear.
- R8: `ext_mode` returns to 0 on the third synchronised `lrck_in` rising edge seen after the last `sclk_in` rising edge. This guarantees two full idle word-select periods.
- R9: Any `sclk_in` rising edge restarts the idle count, so external mode is kept.
- R10: Asserting `rst_n` while in external mode returns the block to internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | External serial bit clock, asynchronous to `clk` |
| lrck_in | input | 1 | Word-select (left/right) clock, asynchronous to `clk` |
| fmt | input | 2 | Format code choosing internal bits per word-select period |
| ext_mode | output | 1 | 1 = external bit clock in use, 0 = internal |
| bit_stb | output | 1 | One-cycle bit strobe from the selected source |
| frame_stb | output | 1 | One-cycle pulse on each word-select rising edge |

## Verification
A wrong phase-edge count shows up at `ext_mode`. Either the mode changes one word-select half too early, or it never changes. This is visible within one word-select half after the 16th edge. A stuck idle counter shows up as external mode that never releases, or that releases before the third silent word-select rising edge. A wrong divider phase or ratio changes how many `bit_stb` pulses fall in one 384-cycle period. It also breaks the coincidence of `bit_stb` with `frame_stb`, so the fault is visible within the first word-select period.

// File: rtl/scm_pkg.sv
package scm_pkg;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } clk_src_e;

  // bit clocks per word-select period for a format code
  function automatic int bits_per_frame(input logic [1:0] code);
    case (code)
      2'b00:   return 32;
      2'b01:   return 48;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/scm_sync.sv
module scm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~last_q;
  assign fall  = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/scm_bclk_gen.sv
module scm_bclk_gen #(
  parameter int MCLK_PER_LRCK = 384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fmt,
  input  logic       lrck_edge,
  output logic       int_stb
);

  import scm_pkg::*;

  localparam int DIV_MAX = MCLK_PER_LRCK / 32;
  localparam int CW      = $clog2(DIV_MAX + 1);
  localparam logic [CW-1:0] DIV32 = CW'(MCLK_PER_LRCK / 32);
  localparam logic [CW-1:0] DIV48 = CW'(MCLK_PER_LRCK / 48);
  localparam logic [CW-1:0] DIV64 = CW'(MCLK_PER_LRCK / 64);

  logic [CW-1:0] div_sel;
  logic [CW-1:0] cnt_q;
  logic          wrap;

  always_comb begin
    case (bits_per_frame(fmt))
      32:      div_sel = DIV32;
      48:      div_sel = DIV48;
      default: div_sel = DIV64;
    endcase
  end

  // wrap also covers a format change that leaves cnt beyond the new limit
  assign wrap    = (cnt_q >= div_sel - CW'(1));
  assign int_stb = lrck_edge | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (int_stb)    cnt_q <= '0;
    else                 cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/scm_mode_fsm.sv
module scm_mode_fsm #(
  parameter int EDGE_THRESH  = 16,
  parameter int IDLE_PERIODS = 2,
  parameter int PH_W         = $clog2(EDGE_THRESH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_rise,
  input  logic            lrck_edge,
  input  logic            lrck_rise,
  output logic            ext_mode,
  output logic [PH_W-1:0] ph_cnt
);

  import scm_pkg::*;

  localparam int IW = $clog2(IDLE_PERIODS + 2);
  localparam logic [PH_W-1:0] TH  = PH_W'(EDGE_THRESH);
  localparam logic [IW-1:0]   LIM = IW'(IDLE_PERIODS + 1);

  clk_src_e        src_q;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [IW-1:0]   idle_q;
  logic            idle_expire;

  always_comb begin
    if (lrck_edge)                    ph_d = sclk_rise ? PH_W'(1) : '0;
    else if (sclk_rise && ph_q != TH) ph_d = ph_q + PH_W'(1);
    else                              ph_d = ph_q;
  end

  assign idle_expire = !sclk_rise && lrck_rise && (idle_q == LIM - IW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      idle_q <= '0;
      src_q  <= SRC_INTERNAL;
    end else begin
      ph_q <= ph_d;
      if (sclk_rise)                       idle_q <= '0;
      else if (lrck_rise && idle_q != LIM) idle_q <= idle_q + IW'(1);
      if (ph_d == TH)                      src_q <= SRC_EXTERNAL;
      else if (idle_expire)                src_q <= SRC_INTERNAL;
    end
  end

  assign ext_mode = (src_q == SRC_EXTERNAL);
  assign ph_cnt   = ph_q;

endmodule

// File: rtl/sclk_mode_detect.sv
module sclk_mode_detect #(
  parameter int MCLK_PER_LRCK = 384,
  parameter int EDGE_THRESH   = 16,
  parameter int IDLE_PERIODS  = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_in,
  input  logic       lrck_in,
  input  logic [1:0] fmt,
  output logic       ext_mode,
  output logic       bit_stb,
  output logic       frame_stb
);

  localparam int PH_W = $clog2(EDGE_THRESH + 1);

  logic            sclk_lvl, sclk_rise, sclk_fall;
  logic            lrck_lvl, lrck_rise, lrck_fall;
  logic            lrck_edge;
  logic            int_stb;
  logic [PH_W-1:0] ph_cnt;

  scm_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk_in),
    .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
  );

  scm_sync #(.STAGES(SYNC_STAGES)) u_lrck_sync (
    .clk(clk), .rst_n(rst_n), .din(lrck_in),
    .level(lrck_lvl), .rise(lrck_rise), .fall(lrck_fall)
  );

  assign lrck_edge = lrck_rise | lrck_fall;

  scm_bclk_gen #(.MCLK_PER_LRCK(MCLK_PER_LRCK)) u_bclk (
    .clk(clk), .rst_n(rst_n), .fmt(fmt),
    .lrck_edge(lrck_edge), .int_stb(int_stb)
  );

  scm_mode_fsm #(
    .EDGE_THRESH(EDGE_THRESH), .IDLE_PERIODS(IDLE_PERIODS), .PH_W(PH_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise),
    .lrck_edge(lrck_edge), .lrck_rise(lrck_rise),
    .ext_mode(ext_mode), .ph_cnt(ph_cnt)
  );

  assign bit_stb   = ext_mode ? sclk_rise : int_stb;
  assign frame_stb = lrck_rise;

endmodule

// File: rtl/scm_checker.sv
module scm_checker #(
  parameter int PH_W   = 5,
  parameter int THRESH = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ext_mode,
  input logic            bit_stb,
  input logic            frame_stb,
  input logic            sclk_rise,
  input logic            lrck_rise,
  input logic [PH_W-1:0] ph_cnt
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_idle_chk: assert (ext_mode == 1'b0 && frame_stb == 1'b0);
    end
  end

  // R3
  int_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && frame_stb) |-> bit_stb);

  // R4
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb);

  // R5
  enter_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_mode) |-> ($past(sclk_rise) && $past(ph_cnt) == PH_W'(THRESH - 1)));

  // R8
  leave_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_mode) |-> ($past(lrck_rise) && !$past(sclk_rise)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_cnt <= PH_W'(THRESH));

endmodule

bind sclk_mode_detect scm_checker #(.PH_W(PH_W), .THRESH(EDGE_THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .bit_stb(bit_stb),
  .frame_stb(frame_stb), .sclk_rise(sclk_rise), .lrck_rise(lrck_rise),
  .ph_cnt(ph_cnt)
);

// File: tb/tb_sclk_mode_detect.sv
`timescale 1ns/1ps
module tb_sclk_mode_detect;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sclk_in;
  logic       lrck_in;
  logic [1:0] fmt;
  logic       ext_mode, bit_stb, frame_stb;

  int total = 0;
  int fails = 0;
  int stb_cnt = 0;
  int frm_cnt = 0;
  int aln_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sclk_mode_detect dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .lrck_in(lrck_in),
    .fmt(fmt), .ext_mode(ext_mode), .bit_stb(bit_stb), .frame_stb(frame_stb)
  );

  always @(negedge clk) begin
    if (bit_stb)              stb_cnt++;
    if (frame_stb)            frm_cnt++;
    if (frame_stb && bit_stb) aln_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // one word-select half: n bit-clock pulses, idle filler, then toggle lrck
  task automatic half_phase(input int n);
    for (int i = 0; i < n; i++) begin
      sclk_in = 1'b1; tick(2);
      sclk_in = 1'b0; tick(2);
    end
    tick(192 - 4 * n);
    lrck_in = ~lrck_in;
  endtask

  task automatic test_reset;
    rst_n = 1'b0; sclk_in = 1'b0; lrck_in = 1'b0; fmt = 2'b00;
    tick(5);
    chk("R1 ext_mode in reset", int'(ext_mode), 0);
    chk("R1 frame_stb in reset", int'(frame_stb), 0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 ext_mode after reset", int'(ext_mode), 0);
  endtask

  task automatic test_ratio(input logic [1:0] f, input int exp);
    int s0, f0, a0;
    fmt = f;
    half_phase(0); half_phase(0);
    s0 = stb_cnt; f0 = frm_cnt; a0 = aln_cnt;
    half_phase(0); half_phase(0);
    chk($sformatf("R2 strobes per period fmt=%0d", f), stb_cnt - s0, exp);
    chk("R4 one frame pulse per period", frm_cnt - f0, 1);
    chk("R3 strobe aligned with frame", aln_cnt - a0, 1);
  endtask

  task automatic test_no_enter;
    half_phase(15); half_phase(0);
    chk("R6 fifteen edges stay internal", int'(ext_mode), 0);
    half_phase(10); half_phase(10); half_phase(0);
    chk("R6 split edges stay internal", int'(ext_mode), 0);
  endtask

  task automatic test_enter(input logic phase_lvl, input string tag);
    if (lrck_in != phase_lvl) half_phase(0);
    half_phase(16);
    tick(3);
    chk(tag, int'(ext_mode), 1);
  endtask

  task automatic test_ext_strobe;
    int s0;
    s0 = stb_cnt;
    half_phase(20);
    chk("R7 one strobe per external edge", stb_cnt - s0, 20);
  endtask

  task automatic test_exit;
    int rises = 0;
    while (rises < 2) begin
      half_phase(0);
      if (lrck_in) rises++;
      tick(5);
      chk("R8 still external before third rise", int'(ext_mode), 1);
    end
    half_phase(1);
    rises = lrck_in ? 1 : 0;
    tick(5);
    chk("R9 edge restarts idle count", int'(ext_mode), 1);
    while (rises < 3) begin
      half_phase(0);
      if (lrck_in) rises++;
      tick(5);
      chk(rises < 3 ? "R9 external kept after restart" : "R8 internal after third rise",
          int'(ext_mode), rises < 3 ? 1 : 0);
    end
  endtask

  task automatic test_reset_ext;
    rst_n = 1'b0;
    tick(2);
    chk("R10 reset clears external mode", int'(ext_mode), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R10 internal after reset release", int'(ext_mode), 0);
  endtask

  initial begin
    test_reset();
    test_ratio(2'b00, 32);
    test_ratio(2'b01, 48);
    test_ratio(2'b10, 64);
    test_ratio(2'b11, 64);
    test_no_enter();
    test_enter(1'b0, "R5 enter during low phase");
    test_ext_strobe();
    test_exit();
    test_enter(1'b1, "R5 enter during high phase");
    test_reset_ext();
    report();
  end

  initial begin
    #(20 * 150000);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule